// File: doc/BRIEF.md
# Frame Occupancy Counters

This block keeps a count of the complete frames held in a receive buffer and in a transmit buffer. The byte storage sits elsewhere. This block only sees frame-boundary events: a frame's final byte being written or read, and a host read of the transmit completion status. From those events it keeps two small saturating counters.

On the receive side the block also decides whether a newly arriving frame may be admitted. When the receive count is already at its ceiling, the frame is refused. If that refused frame was addressed to this station, the refusal is recorded in an 8-bit lost-frame counter. When that counter reaches its ceiling, it raises a single-cycle pulse for the interrupt logic.

Top module: `frame_occupancy_ctr`

## Requirements
- R1: After reset, both frame counts and the lost-frame count are 0, and the overflow pulse is low.
- R2: The receive count rises by 1 in the cycle after an admitted end-of-frame write. It falls by 1 in the cycle after an end-of-frame read.
- R3: While the receive count is 15, `rx_admit` is low during an end-of-frame write, and the write does not raise the count.
- R4: A refused receive frame raises the lost-frame count by 1 only when `rx_addr_hit` is high with the write. A refused frame with `rx_addr_hit` low leaves the lost-frame count unchanged.
- R5: The transmit count rises by 1 after an end-of-frame write. It falls by 1 only after a status read made while `tx_stat_valid` is high. A status read without valid, or valid without a read, changes nothing.
- R6: The lost-frame count holds at 255. `lost_ovf` is high for exactly the one cycle in which the count first shows 255. Later refused frames do not pulse `lost_ovf` again.
- R7: An increment and a decrement of the same counter in the same cycle leave that counter unchanged.
- R8: A decrement at 0 is ignored. A transmit end-of-frame write at 15 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_eof_wr | input | 1 | Final byte of an arriving receive frame |
| rx_addr_hit | input | 1 | Arriving frame matched the station address |
| rx_eof_rd | input | 1 | Host read the final byte of a receive frame |
| tx_eof_wr | input | 1 | Final byte of a transmit frame written |
| tx_stat_rd | input | 1 | Host read of the transmit frame status |
| tx_stat_valid | input | 1 | Transmit status holds a completed result |
| rx_admit | output | 1 | Arriving frame is accepted this cycle |
| rx_frames | output | 4 | Receive frames held |
| tx_frames | output | 4 | Transmit frames held |
| lost_frames | output | 8 | Address-matched frames refused for lack of room |
| lost_ovf | output | 1 | One-cycle pulse when the lost-frame count reaches 255 |

## Verification
A wrong internal count appears on `rx_frames` or `tx_frames` one cycle after the event that caused it. It then persists, because every later event only moves the value by one. A wrong full decision shows up in the same cycle on `rx_admit`, and one cycle later on `lost_frames`. The bench therefore compares every count after each event. It also pushes each counter into its end stops, where underflow, wrap-around or a repeated overflow pulse would first become visible.

// File: rtl/frame_occupancy_ctr.sv
module frame_occupancy_ctr #(
  parameter int CNT_W  = 4,
  parameter int LOST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_eof_wr,
  input  logic              rx_addr_hit,
  input  logic              rx_eof_rd,
  input  logic              tx_eof_wr,
  input  logic              tx_stat_rd,
  input  logic              tx_stat_valid,
  output logic              rx_admit,
  output logic [CNT_W-1:0]  rx_frames,
  output logic [CNT_W-1:0]  tx_frames,
  output logic [LOST_W-1:0] lost_frames,
  output logic              lost_ovf
);
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
  localparam logic [CNT_W-1:0]  CNT_ONE  = 1;
  localparam logic [LOST_W-1:0] LOST_MAX = '1;
  localparam logic [LOST_W-1:0] LOST_ONE = 1;

  logic rx_full, rx_inc, rx_dec, tx_inc, tx_dec, lost_inc;

  assign rx_full  = (rx_frames == CNT_MAX);
  assign rx_admit = rx_eof_wr && !rx_full;
  assign rx_inc   = rx_admit;
  assign rx_dec   = rx_eof_rd && (rx_frames != '0);
  assign tx_inc   = tx_eof_wr && (tx_frames != CNT_MAX);
  assign tx_dec   = tx_stat_rd && tx_stat_valid && (tx_frames != '0);
  assign lost_inc = rx_eof_wr && rx_full && rx_addr_hit && (lost_frames != LOST_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_frames   <= '0;
      tx_frames   <= '0;
      lost_frames <= '0;
      lost_ovf    <= 1'b0;
    end else begin
      if (rx_inc && !rx_dec)      rx_frames <= rx_frames + CNT_ONE;
      else if (rx_dec && !rx_inc) rx_frames <= rx_frames - CNT_ONE;
      if (tx_inc && !tx_dec)      tx_frames <= tx_frames + CNT_ONE;
      else if (tx_dec && !tx_inc) tx_frames <= tx_frames - CNT_ONE;
      if (lost_inc) lost_frames <= lost_frames + LOST_ONE;
      lost_ovf <= lost_inc && (lost_frames == LOST_MAX - LOST_ONE);
    end
  end

  AST_RX_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_eof_wr && rx_frames == CNT_MAX && !rx_eof_rd) |=> rx_frames == CNT_MAX); // R3
  AST_RX_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_frames == '0 && !rx_eof_wr) |=> rx_frames == '0); // R8
  AST_TX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_eof_wr && !(tx_stat_rd && tx_stat_valid)) |=> $stable(tx_frames)); // R5
  AST_LOST_ONLY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_eof_wr && rx_addr_hit) |=> $stable(lost_frames)); // R4
  AST_LOST_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    lost_frames == LOST_MAX |=> lost_frames == LOST_MAX); // R6
  AST_OVF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    lost_ovf |=> !lost_ovf); // R6
  AST_RX_BALANCED: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_eof_wr && rx_eof_rd && rx_frames != CNT_MAX && rx_frames != '0) |=> $stable(rx_frames)); // R7
endmodule

// File: tb/frame_occupancy_ctr_tb.sv
module frame_occupancy_ctr_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_eof_wr = 0, rx_addr_hit = 0, rx_eof_rd = 0;
  logic tx_eof_wr = 0, tx_stat_rd = 0, tx_stat_valid = 0;
  logic       rx_admit, lost_ovf;
  logic [3:0] rx_frames, tx_frames;
  logic [7:0] lost_frames;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  frame_occupancy_ctr u_dut (
    .clk(clk), .rst_n(rst_n),
    .rx_eof_wr(rx_eof_wr), .rx_addr_hit(rx_addr_hit), .rx_eof_rd(rx_eof_rd),
    .tx_eof_wr(tx_eof_wr), .tx_stat_rd(tx_stat_rd), .tx_stat_valid(tx_stat_valid),
    .rx_admit(rx_admit), .rx_frames(rx_frames), .tx_frames(tx_frames),
    .lost_frames(lost_frames), .lost_ovf(lost_ovf)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic rw, input logic rh, input logic rr,
                     input logic tw, input logic tr, input logic tv);
    rx_eof_wr = rw; rx_addr_hit = rh; rx_eof_rd = rr;
    tx_eof_wr = tw; tx_stat_rd = tr; tx_stat_valid = tv;
    @(posedge clk);
    @(negedge clk);
    rx_eof_wr = 0; rx_addr_hit = 0; rx_eof_rd = 0;
    tx_eof_wr = 0; tx_stat_rd = 0; tx_stat_valid = 0;
  endtask

  task automatic t_reset;
    chk("R1 rx_frames", rx_frames, 0);
    chk("R1 tx_frames", tx_frames, 0);
    chk("R1 lost_frames", lost_frames, 0);
    chk("R1 lost_ovf", lost_ovf, 0);
  endtask

  task automatic t_rx_basic;
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0, 0);
    chk("R2 rx after 3 writes", rx_frames, 3);
    cyc(0, 0, 1, 0, 0, 0);
    chk("R2 rx after read", rx_frames, 2);
    cyc(1, 1, 1, 0, 0, 0);
    chk("R7 rx write+read", rx_frames, 2);
    cyc(0, 0, 1, 0, 0, 0);
    cyc(0, 0, 1, 0, 0, 0);
    chk("R2 rx drained", rx_frames, 0);
    cyc(0, 0, 1, 0, 0, 0);
    chk("R8 rx read at zero", rx_frames, 0);
  endtask

  task automatic t_rx_full;
    for (int i = 0; i < 15; i++) cyc(1, 0, 0, 0, 0, 0);
    chk("R2 rx filled", rx_frames, 15);
    rx_eof_wr = 1; rx_addr_hit = 0;
    #1 chk("R3 rx_admit low when full", rx_admit, 0);
    cyc(1, 0, 0, 0, 0, 0);
    chk("R3 rx stays 15", rx_frames, 15);
    chk("R4 miss without hit not counted", lost_frames, 0);
    cyc(1, 1, 0, 0, 0, 0);
    chk("R4 miss with hit counted", lost_frames, 1);
    chk("R3 rx still 15", rx_frames, 15);
  endtask

  task automatic t_lost_sat;
    for (int i = 0; i < 253; i++) cyc(1, 1, 0, 0, 0, 0);
    chk("R6 lost at 254", lost_frames, 254);
    chk("R6 no pulse before 255", lost_ovf, 0);
    cyc(1, 1, 0, 0, 0, 0);
    chk("R6 lost at 255", lost_frames, 255);
    chk("R6 pulse at 255", lost_ovf, 1);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R6 pulse one cycle", lost_ovf, 0);
    cyc(1, 1, 0, 0, 0, 0);
    chk("R6 lost saturates", lost_frames, 255);
    chk("R6 no second pulse", lost_ovf, 0);
  endtask

  task automatic t_tx;
    cyc(0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R5 tx after 2 writes", tx_frames, 2);
    cyc(0, 0, 0, 0, 1, 0);
    chk("R5 status read without valid", tx_frames, 2);
    cyc(0, 0, 0, 0, 0, 1);
    chk("R5 valid without read", tx_frames, 2);
    cyc(0, 0, 0, 0, 1, 1);
    chk("R5 valid status read", tx_frames, 1);
    cyc(0, 0, 0, 1, 1, 1);
    chk("R7 tx write+dec", tx_frames, 1);
    cyc(0, 0, 0, 0, 1, 1);
    cyc(0, 0, 0, 0, 1, 1);
    chk("R8 tx dec at zero", tx_frames, 0);
    for (int i = 0; i < 16; i++) cyc(0, 0, 0, 1, 0, 0);
    chk("R8 tx holds at 15", tx_frames, 15);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rx_basic();
    t_rx_full();
    t_lost_sat();
    t_tx();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule